// File: doc/BRIEF.md
# Base Address Window Validator

This block decides, for one device, which of its address windows are live and where each one sits. It looks at up to six base address registers and one expansion ROM register, together with the I/O-enable and memory-enable bits of the device's command register and the size and kind that each window was built with. For every window it reports whether it is mapped and, if so, its base with the low bits cleared. Beyond simple masking it turns away windows whose placement cannot be honoured: a base of zero, a window that wraps, an I/O window reaching past the 64 KiB port space, a 32-bit memory window touching the top of the 4 GiB space, and a ROM window whose enable bit is clear.

The same results feed an address decoder: an incoming address, tagged as an I/O or a memory request, is compared against every mapped window of the matching space. Each window also has a registered pulse that marks a change in its mapped state, so that downstream mapping logic can react. All mapping results and hits are combinational in the register inputs; only the change pulses are clocked.

Top module: `bar_window_validator`

## Requirements
- R1: Each BAR window has a 2-bit kind: 00 I/O, 01 32-bit memory, 10 64-bit memory, 11 behaves as 32-bit memory. The ROM window is always 32-bit memory. An I/O window can map only while `cmd_io_en` is 1; a memory or ROM window can map only while `cmd_mem_en` is 1.
- R2: The candidate base is the register value ANDed with ~(size-1) and its last address is base+size-1; `base_o` carries that base when the window is mapped and zero otherwise.
- R3: An I/O window is unmapped when its last address is not above its base, when its base is zero, or when its last address is 0x10000 or higher.
- R4: A memory window (including the ROM) is unmapped when its last address, computed in 64 bits, is not above its base, when its base is zero, or when its last address is all ones.
- R5: A 32-bit memory window (kinds 01 and 11, and the ROM) is also unmapped when its last address is 0xFFFFFFFF or higher.
- R6: A 64-bit memory window at BAR i takes its low 32 bits from BAR i and its high 32 bits from BAR i+1; at the last BAR the high half is zero.
- R7: The ROM window maps only while bit 0 of `rom_raw` is 1.
- R8: A window whose size is zero is not implemented and never maps.
- R9: `hit_o[i]` is 1 exactly when window i is mapped, the request space (`req_io`=1 for I/O, 0 for memory) matches the window's kind, and `req_addr` ANDed with ~(size-1) equals the window's base.
- R10: `map_chg_o[i]` is a registered pulse: it is 1 in the cycle after a rising clock edge at which `mapped_o[i]` differed from its value at the previous edge (taken as 0 after reset), and 0 otherwise; reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the change pulses |
| rst_n | input | 1 | Active-low reset |
| cmd_io_en | input | 1 | Command register I/O-space enable |
| cmd_mem_en | input | 1 | Command register memory-space enable |
| bar_raw | input | NUM_BARS*32 | Raw BAR contents, BAR i at bits [i*32 +: 32] |
| rom_raw | input | 32 | Raw expansion ROM register, bit 0 is the enable |
| reg_size | input | (NUM_BARS+1)*64 | Window sizes (power of two or zero), ROM in the top slot |
| reg_kind | input | NUM_BARS*2 | Window kinds for the BARs |
| req_addr | input | 64 | Address of an incoming request |
| req_io | input | 1 | 1 for an I/O request, 0 for a memory request |
| mapped_o | output | NUM_BARS+1 | Window mapped flags, ROM in the top bit |
| base_o | output | (NUM_BARS+1)*64 | Aligned bases of mapped windows, zero when unmapped |
| hit_o | output | NUM_BARS+1 | Per-window request hits |
| map_chg_o | output | NUM_BARS+1 | Registered mapped-state change pulses |

## Verification
The assertions take for granted that every window size is zero or a power of two and that the kind of a 64-bit window's upper neighbour is left at size zero, since the block does not police its own configuration. The stimulus holds to this by building every size as a single shifted one or as zero, and by leaving every window other than the one under test, plus the ROM, at size zero or at a legal power of two. Within those bounds it sweeps the kinds, a set of sizes from one byte to 2 GiB, raw values chosen to sit on the zero, 64 KiB, 4 GiB and all-ones edges, and all four enable combinations.

// File: rtl/bwv_pkg.sv
package bwv_pkg;

  typedef enum logic [1:0] {
    KIND_IO   = 2'b00,
    KIND_M32  = 2'b01,
    KIND_M64  = 2'b10,
    KIND_M32B = 2'b11
  } region_kind_e;

  localparam logic [63:0] ADDR_ONES = '1;
  localparam logic [63:0] LIMIT_4G  = 64'h0000_0000_FFFF_FFFF;

  // Clear the bits that fall inside the window.
  function automatic logic [63:0] align_base(input logic [63:0] v, input logic [63:0] sz);
    return v & ~(sz - 64'd1);
  endfunction

  // Last byte of a window, wrapping in 64 bits.
  function automatic logic [63:0] last_addr(input logic [63:0] b, input logic [63:0] sz);
    return b + sz - 64'd1;
  endfunction

  function automatic logic kind_is_io(input region_kind_e k);
    return k == KIND_IO;
  endfunction

  function automatic logic kind_is_wide(input region_kind_e k);
    return k == KIND_M64;
  endfunction

endpackage

// File: rtl/bwv_region_eval.sv
module bwv_region_eval
  import bwv_pkg::*;
#(
  parameter bit          IS_ROM   = 1'b0,
  parameter logic [63:0] IO_LIMIT = 64'h1_0000
) (
  input  logic         io_en,
  input  logic         mem_en,
  input  logic [63:0]  raw,
  input  logic [63:0]  size,
  input  region_kind_e kind,
  output logic         mapped,
  output logic [63:0]  base
);

  logic [63:0] cand;
  logic [63:0] last;
  logic        space_on;
  logic        rej_absent;
  logic        rej_wrap;
  logic        rej_zero;
  logic        rej_io_limit;
  logic        rej_ones;
  logic        rej_m32;
  logic        rej_rom;

  always_comb begin
    cand         = align_base(raw, size);
    last         = last_addr(cand, size);
    space_on     = kind_is_io(kind) ? io_en : mem_en;
    rej_absent   = (size == 64'd0);
    rej_wrap     = (last <= cand);
    rej_zero     = (cand == 64'd0);
    rej_io_limit = kind_is_io(kind) && (last >= IO_LIMIT);
    rej_ones     = !kind_is_io(kind) && (last == ADDR_ONES);
    rej_m32      = !kind_is_io(kind) && !kind_is_wide(kind) && (last >= LIMIT_4G);
    rej_rom      = IS_ROM && !raw[0];
    mapped       = space_on && !(rej_absent || rej_wrap || rej_zero || rej_io_limit ||
                                 rej_ones || rej_m32 || rej_rom);
    base         = mapped ? cand : 64'd0;
  end

endmodule

// File: rtl/bwv_window_hit.sv
module bwv_window_hit
  import bwv_pkg::*;
(
  input  logic         mapped,
  input  logic [63:0]  base,
  input  logic [63:0]  size,
  input  region_kind_e kind,
  input  logic [63:0]  req_addr,
  input  logic         req_io,
  output logic         hit
);

  logic space_match;
  logic addr_match;

  always_comb begin
    space_match = (req_io == kind_is_io(kind));
    addr_match  = (align_base(req_addr, size) == base);
    hit         = mapped && space_match && addr_match;
  end

endmodule

// File: rtl/bwv_change_track.sv
module bwv_change_track #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] mapped,
  output logic [N-1:0] chg
);

  logic [N-1:0] mapped_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mapped_q <= '0;
      chg      <= '0;
    end else begin
      mapped_q <= mapped;
      chg      <= mapped ^ mapped_q;
    end
  end

endmodule

// File: rtl/bar_window_validator.sv
module bar_window_validator
  import bwv_pkg::*;
#(
  parameter int          NUM_BARS = 6,
  parameter logic [63:0] IO_LIMIT = 64'h1_0000,
  localparam int         NREG     = NUM_BARS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_io_en,
  input  logic                 cmd_mem_en,
  input  logic [NUM_BARS*32-1:0] bar_raw,
  input  logic [31:0]          rom_raw,
  input  logic [NREG*64-1:0]   reg_size,
  input  logic [NUM_BARS*2-1:0] reg_kind,
  input  logic [63:0]          req_addr,
  input  logic                 req_io,
  output logic [NREG-1:0]      mapped_o,
  output logic [NREG*64-1:0]   base_o,
  output logic [NREG-1:0]      hit_o,
  output logic [NREG-1:0]      map_chg_o
);

  region_kind_e kind_w [NREG];
  logic [63:0]  raw_w  [NREG];
  logic [63:0]  base_w [NREG];

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    logic [31:0] hi_half;
    if (g + 1 < NUM_BARS) begin : g_hi
      assign hi_half = bar_raw[(g+1)*32 +: 32];
    end else begin : g_top
      assign hi_half = 32'd0;
    end
    assign kind_w[g] = region_kind_e'(reg_kind[g*2 +: 2]);
    assign raw_w[g]  = kind_is_wide(kind_w[g]) ? {hi_half, bar_raw[g*32 +: 32]}
                                               : {32'd0, bar_raw[g*32 +: 32]};
    bwv_region_eval #(.IS_ROM(1'b0), .IO_LIMIT(IO_LIMIT)) u_eval (
      .io_en (cmd_io_en),
      .mem_en(cmd_mem_en),
      .raw   (raw_w[g]),
      .size  (reg_size[g*64 +: 64]),
      .kind  (kind_w[g]),
      .mapped(mapped_o[g]),
      .base  (base_w[g])
    );
  end

  assign kind_w[NUM_BARS] = KIND_M32;
  assign raw_w[NUM_BARS]  = {32'd0, rom_raw};

  bwv_region_eval #(.IS_ROM(1'b1), .IO_LIMIT(IO_LIMIT)) u_rom_eval (
    .io_en (cmd_io_en),
    .mem_en(cmd_mem_en),
    .raw   (raw_w[NUM_BARS]),
    .size  (reg_size[NUM_BARS*64 +: 64]),
    .kind  (kind_w[NUM_BARS]),
    .mapped(mapped_o[NUM_BARS]),
    .base  (base_w[NUM_BARS])
  );

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign base_o[g*64 +: 64] = base_w[g];
    bwv_window_hit u_hit (
      .mapped  (mapped_o[g]),
      .base    (base_w[g]),
      .size    (reg_size[g*64 +: 64]),
      .kind    (kind_w[g]),
      .req_addr(req_addr),
      .req_io  (req_io),
      .hit     (hit_o[g])
    );
  end

  bwv_change_track #(.N(NREG)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .mapped(mapped_o),
    .chg   (map_chg_o)
  );

endmodule

// File: rtl/bwv_checker.sv
module bwv_checker #(
  parameter int          NUM_BARS = 6,
  parameter logic [63:0] IO_LIMIT = 64'h1_0000,
  localparam int         NREG     = NUM_BARS + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_io_en,
  input logic                  cmd_mem_en,
  input logic [31:0]           rom_raw,
  input logic [NREG*64-1:0]    reg_size,
  input logic [NUM_BARS*2-1:0] reg_kind,
  input logic [NREG-1:0]       mapped_o,
  input logic [NREG*64-1:0]    base_o,
  input logic [NREG-1:0]       hit_o,
  input logic [NREG-1:0]       map_chg_o
);

  logic [NREG-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= mapped_o;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    logic        io_w;
    logic [63:0] sz_w;
    logic [63:0] bs_w;
    if (g < NUM_BARS) begin : g_k
      assign io_w = (reg_kind[g*2 +: 2] == 2'b00);
    end else begin : g_r
      assign io_w = 1'b0;
    end
    assign sz_w = reg_size[g*64 +: 64];
    assign bs_w = base_o[g*64 +: 64];

    AST_IO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_w && !cmd_io_en) |-> !mapped_o[g]);                              // R1
    AST_MEM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_w && !cmd_mem_en) |-> !mapped_o[g]);                            // R1
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mapped_o[g] |-> ((bs_w & (sz_w - 64'd1)) == 64'd0));                 // R2
    AST_UNMAPPED_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped_o[g] |-> (bs_w == 64'd0));                                   // R2
    AST_IO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mapped_o[g] && io_w) |-> (bs_w + sz_w <= IO_LIMIT));                // R3
    AST_NONZERO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      mapped_o[g] |-> (bs_w != 64'd0));                                    // R4
    AST_NO_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (mapped_o[g] && !io_w) |-> (bs_w + sz_w - 64'd1 != '1));             // R4
    AST_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sz_w == 64'd0) |-> !mapped_o[g]);                                   // R8
    AST_HIT_NEEDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o[g] |-> mapped_o[g]);                                           // R9
    AST_CHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mapped_o[g] != seen_q[g]) |=> map_chg_o[g]);                        // R10
    AST_CHG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (mapped_o[g] == seen_q[g]) |=> !map_chg_o[g]);                       // R10
  end

  AST_ROM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mapped_o[NUM_BARS] |-> rom_raw[0]);                                    // R7

endmodule

bind bar_window_validator bwv_checker #(.NUM_BARS(NUM_BARS), .IO_LIMIT(IO_LIMIT)) u_bwv_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_io_en (cmd_io_en),
  .cmd_mem_en(cmd_mem_en),
  .rom_raw   (rom_raw),
  .reg_size  (reg_size),
  .reg_kind  (reg_kind),
  .mapped_o  (mapped_o),
  .base_o    (base_o),
  .hit_o     (hit_o),
  .map_chg_o (map_chg_o)
);

// File: tb/bar_window_validator_test.sv
module bar_window_validator_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 6;
  localparam int NREG = NB + 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cmd_io_en = 1'b0;
  logic                cmd_mem_en = 1'b0;
  logic [NB*32-1:0]    bar_raw = '0;
  logic [31:0]         rom_raw = '0;
  logic [NREG*64-1:0]  reg_size = '0;
  logic [NB*2-1:0]     reg_kind = '0;
  logic [63:0]         req_addr = '0;
  logic                req_io = 1'b0;
  logic [NREG-1:0]     mapped_o;
  logic [NREG*64-1:0]  base_o;
  logic [NREG-1:0]     hit_o;
  logic [NREG-1:0]     map_chg_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bar_window_validator #(.NUM_BARS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
    .bar_raw(bar_raw), .rom_raw(rom_raw), .reg_size(reg_size), .reg_kind(reg_kind),
    .req_addr(req_addr), .req_io(req_io), .mapped_o(mapped_o), .base_o(base_o),
    .hit_o(hit_o), .map_chg_o(map_chg_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Independent model: shift-based alignment, 65-bit last address.
  function automatic void model(input int kind, input int lg, input logic [63:0] raw,
                                input bit io_en, input bit mem_en, input bit rom,
                                output bit m, output logic [63:0] b);
    logic [63:0] al;
    logic [64:0] last;
    m = 1'b0;
    b = 64'd0;
    if (lg < 0) return;
    al   = (raw >> lg) << lg;
    last = {1'b0, al} + (65'd1 << lg) - 65'd1;
    if (kind == 0) begin
      if (!io_en) return;
      if (lg == 0 || al == 64'd0 || last >= 65'h1_0000) return;
    end else begin
      if (!mem_en) return;
      if (rom && !raw[0]) return;
      if (lg == 0 || al == 64'd0 || last >= {1'b0, 64'hFFFF_FFFF_FFFF_FFFF}) return;
      if (kind != 2 && last >= 65'hFFFF_FFFF) return;
    end
    m = 1'b1;
    b = al;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    summary();
  end

  initial begin
    int lgs [10] = '{-1, 0, 1, 2, 4, 8, 12, 16, 24, 31};
    logic [31:0] raws [9] = '{32'h0000_0000, 32'h0000_1000, 32'h0000_FFF1, 32'h0000_C001,
                              32'hFFFF_F000, 32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF,
                              32'h1234_5679};
    bit m_e, m_r;
    logic [63:0] b_e, b_r, sz, raw64;
    string tg;

    repeat (3) @(negedge clk);
    check(map_chg_o == '0, "R10 reset pulse", {57'd0, map_chg_o}, 64'd0);
    check(mapped_o == '0, "R8 reset all sizes zero", {57'd0, mapped_o}, 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 3; k++) begin
      for (int li = 0; li < 10; li++) begin
        for (int ri = 0; ri < 9; ri++) begin
          for (int en = 0; en < 4; en++) begin
            logic [31:0] hi;
            hi = (ri % 3 == 0) ? 32'd0 : (ri % 3 == 1) ? 32'd1 : 32'hFFFF_FFFF;
            sz = (lgs[li] < 0) ? 64'd0 : (64'd1 << lgs[li]);
            @(negedge clk);
            cmd_io_en  = en[0];
            cmd_mem_en = en[1];
            bar_raw    = '0;
            bar_raw[31:0]  = raws[ri];
            bar_raw[63:32] = hi;
            reg_kind   = '0;
            reg_kind[1:0] = k[1:0];
            reg_size   = '0;
            reg_size[63:0] = sz;
            reg_size[NB*64 +: 64] = sz;
            rom_raw    = raws[ri];
            raw64 = (k == 2) ? {hi, raws[ri]} : {32'd0, raws[ri]};
            model(k, lgs[li], raw64, en[0], en[1], 1'b0, m_e, b_e);
            model(1, lgs[li], {32'd0, raws[ri]}, en[0], en[1], 1'b1, m_r, b_r);
            tg = (k == 0) ? "R1/R3" : (k == 1) ? "R4/R5" : "R4/R6";
            #1;
            check(mapped_o[0] == m_e, {tg, " mapped"}, {63'd0, mapped_o[0]}, {63'd0, m_e});
            check(base_o[63:0] == b_e, {"R2 base ", tg}, base_o[63:0], b_e);
            check(mapped_o[NB] == m_r, "R7/R5 rom mapped", {63'd0, mapped_o[NB]}, {63'd0, m_r});
            check(base_o[NB*64 +: 64] == b_r, "R2 rom base", base_o[NB*64 +: 64], b_r);
            check(mapped_o[NB-1:1] == '0, "R8 size zero", {59'd0, mapped_o[NB-1:1]}, 64'd0);
            if (m_e) begin
              req_addr = b_e + (sz >> 1);
              req_io   = (k == 0);
              #1;
              check(hit_o[0] == 1'b1, "R9 hit inside", {63'd0, hit_o[0]}, 64'd1);
              req_io = (k != 0);
              #1;
              check(hit_o[0] == 1'b0, "R9 space mismatch", {63'd0, hit_o[0]}, 64'd0);
              req_io   = (k == 0);
              req_addr = b_e + sz;
              #1;
              check(hit_o[0] == 1'b0, "R9 past end", {63'd0, hit_o[0]}, 64'd0);
            end
            if (m_r) begin
              req_addr = b_r;
              req_io   = 1'b0;
              #1;
              check(hit_o[NB] == 1'b1, "R9 rom hit", {63'd0, hit_o[NB]}, 64'd1);
              req_io = 1'b1;
              #1;
              check(hit_o[NB] == 1'b0, "R9 rom io miss", {63'd0, hit_o[NB]}, 64'd0);
            end
          end
        end
      end
    end

    // R10: change pulses around an I/O window toggled by its enable.
    @(negedge clk);
    reg_size = '0;
    reg_size[63:0] = 64'd16;
    reg_kind = '0;
    bar_raw  = '0;
    bar_raw[31:0] = 32'h0000_1000;
    cmd_io_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(map_chg_o[0] == 1'b0, "R10 quiet", {63'd0, map_chg_o[0]}, 64'd0);
    cmd_io_en = 1'b1;
    @(negedge clk);
    check(map_chg_o[0] == 1'b1, "R10 rise pulse", {63'd0, map_chg_o[0]}, 64'd1);
    check(mapped_o[0] == 1'b1, "R1 io enabled", {63'd0, mapped_o[0]}, 64'd1);
    @(negedge clk);
    check(map_chg_o[0] == 1'b0, "R10 pulse one cycle", {63'd0, map_chg_o[0]}, 64'd0);
    cmd_io_en = 1'b0;
    @(negedge clk);
    check(map_chg_o[0] == 1'b1, "R10 fall pulse", {63'd0, map_chg_o[0]}, 64'd1);
    check(map_chg_o[NB:1] == '0, "R10 other windows", {58'd0, map_chg_o[NB:1]}, 64'd0);

    // R6: 64-bit window at the last BAR has a zero high half.
    reg_size = '0;
    reg_size[(NB-1)*64 +: 64] = 64'd4096;
    reg_kind = '0;
    reg_kind[(NB-1)*2 +: 2] = 2'b10;
    bar_raw  = '0;
    bar_raw[(NB-1)*32 +: 32] = 32'h4000_0000;
    cmd_mem_en = 1'b1;
    #1;
    check(base_o[(NB-1)*64 +: 64] == 64'h4000_0000, "R6 last bar high zero",
          base_o[(NB-1)*64 +: 64], 64'h4000_0000);
    reg_kind[(NB-1)*2 +: 2] = 2'b11;
    #1;
    check(mapped_o[NB-1] == 1'b1, "R1 kind 11 as memory", {63'd0, mapped_o[NB-1]}, 64'd1);

    summary();
  end

endmodule